// File: doc/BRIEF.md
# Compare-Set Integer ALU

A 32-bit integer execution unit for a three-address RISC core. Each cycle it may accept two source operands, a 16-bit immediate and an operation code. One clock edge later it presents a registered result together with a valid flag.

The operation set has four groups:
- Wrapping add and subtract.
- An eight-member bitwise logic family plus one's complement.
- Absolute value and negated absolute value.
- Compare-and-set operations that write a full word holding exactly 1 or 0.

Immediate forms extend the 16-bit field in the way each operation needs:
- Sign extension for add-immediate and signed compares.
- Zero extension for the logic immediates and unsigned compares.
- Placement in the upper half-word for the add-shifted form.

Top module: `cset_alu`

## Requirements
- R1: While rst_ni is low, valid_o and result_o read 0.
- R2: valid_o is high exactly on the cycle after a cycle with valid_i high. result_o loads only on an accepted operation and holds its value while valid_i is low.
- R3: op 0x00 gives a_i + b_i and op 0x01 gives a_i - b_i. Both wrap modulo 2^32 with no overflow indication.
- R4: op 0x02 adds the sign-extended immediate to a_i. op 0x03 adds the immediate shifted into bits 31:16, with bits 15:0 zero, to a_i.
- R5: Register logic ops act on a_i and b_i: 0x04 and, 0x05 or, 0x06 xor, 0x07 a and not b, 0x08 xnor, 0x09 nand, 0x0A nor, 0x0B a or not b. op 0x0C gives the bitwise complement of a_i.
- R6: ops 0x0D, 0x0E and 0x0F give and, or and xor of a_i with the zero-extended immediate.
- R7: op 0x10 gives the magnitude of a_i and op 0x11 gives the negated magnitude. Both return 0x80000000 for an input of 0x80000000.
- R8: Register compares give 1 when true and 0 when false. Signed: 0x14 eq, 0x15 ne, 0x16 lt, 0x17 le, 0x18 gt, 0x19 ge. Unsigned: 0x1A lt, 0x1B le, 0x1C gt, 0x1D ge.
- R9: Immediate compares of a_i give 1 or 0. 0x20..0x25 (eq, ne, lt, le, gt, ge) use the sign-extended immediate with a signed order. 0x26..0x2B (same predicate order) use the zero-extended immediate with an unsigned order.
- R10: Any opcode not listed above returns a result of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 6 | Operation code |
| a_i | input | 32 | Source operand A |
| b_i | input | 32 | Source operand B |
| imm_i | input | 16 | Immediate field |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| result_o | output | 32 | Registered result |

## Verification
The bench builds the block at its defaults: a 32-bit word and a 16-bit immediate. At these widths, immediates with bit 15 set separate sign extension from zero extension, and the same field lands exactly on the upper half-word for the add-shifted form. The word minimum 0x80000000 is reachable for the absolute-value corner case. Operands of -1 against 1 and 0xFFFFFFFE against 0xFFFF make signed and unsigned orderings give opposite answers on the same inputs.

// File: rtl/cset_alu_pkg.sv
package cset_alu_pkg;

  localparam int OP_W = 6;

  localparam logic [OP_W-1:0] OP_ADD   = 6'h00;
  localparam logic [OP_W-1:0] OP_SUB   = 6'h01;
  localparam logic [OP_W-1:0] OP_ADDI  = 6'h02;
  localparam logic [OP_W-1:0] OP_ADDIS = 6'h03;
  localparam logic [OP_W-1:0] OP_AND   = 6'h04;
  localparam logic [OP_W-1:0] OP_NOT   = 6'h0C;
  localparam logic [OP_W-1:0] OP_ANDI  = 6'h0D;
  localparam logic [OP_W-1:0] OP_XORI  = 6'h0F;
  localparam logic [OP_W-1:0] OP_ABS   = 6'h10;
  localparam logic [OP_W-1:0] OP_NABS  = 6'h11;
  localparam logic [OP_W-1:0] OP_CEQ   = 6'h14;
  localparam logic [OP_W-1:0] OP_CGE   = 6'h19;
  localparam logic [OP_W-1:0] OP_CLTU  = 6'h1A;
  localparam logic [OP_W-1:0] OP_CGEU  = 6'h1D;
  localparam logic [OP_W-1:0] OP_CIEQ  = 6'h20;
  localparam logic [OP_W-1:0] OP_CIGE  = 6'h25;
  localparam logic [OP_W-1:0] OP_CIEQU = 6'h26;
  localparam logic [OP_W-1:0] OP_CIGEU = 6'h2B;

  typedef enum logic [1:0] {U_NONE, U_ARITH, U_LOGIC, U_CMP} unit_e;
  typedef enum logic [1:0] {B_REG, B_SEXT, B_ZEXT, B_HIGH} bsel_e;

  // arith fn
  localparam logic [3:0] AF_ADD = 4'd0, AF_SUB = 4'd1, AF_ABS = 4'd2, AF_NABS = 4'd3;
  // logic fn
  localparam logic [3:0] LF_AND = 4'd0, LF_OR = 4'd1, LF_XOR = 4'd2, LF_ANDC = 4'd3,
                         LF_EQV = 4'd4, LF_NAND = 4'd5, LF_NOR = 4'd6, LF_ORC = 4'd7,
                         LF_NOT = 4'd8;
  // compare predicate fn
  localparam logic [3:0] CF_EQ = 4'd0, CF_NE = 4'd1, CF_LT = 4'd2, CF_LE = 4'd3,
                         CF_GT = 4'd4, CF_GE = 4'd5;

  typedef struct packed {
    unit_e      unit;
    bsel_e      bsel;
    logic [3:0] fn;
    logic       sgn;
  } dec_t;

  function automatic dec_t decode(input logic [OP_W-1:0] op);
    dec_t d;
    d = '{unit: U_NONE, bsel: B_REG, fn: 4'd0, sgn: 1'b0};
    if (op == OP_ADD || op == OP_SUB) begin
      d.unit = U_ARITH;
      d.fn   = (op == OP_SUB) ? AF_SUB : AF_ADD;
    end else if (op == OP_ADDI || op == OP_ADDIS) begin
      d.unit = U_ARITH;
      d.fn   = AF_ADD;
      d.bsel = (op == OP_ADDIS) ? B_HIGH : B_SEXT;
    end else if (op >= OP_AND && op <= OP_NOT) begin
      d.unit = U_LOGIC;
      d.fn   = 4'(op - OP_AND);
    end else if (op >= OP_ANDI && op <= OP_XORI) begin
      d.unit = U_LOGIC;
      d.fn   = 4'(op - OP_ANDI);
      d.bsel = B_ZEXT;
    end else if (op == OP_ABS || op == OP_NABS) begin
      d.unit = U_ARITH;
      d.fn   = (op == OP_ABS) ? AF_ABS : AF_NABS;
    end else if (op >= OP_CEQ && op <= OP_CGE) begin
      d.unit = U_CMP;
      d.fn   = 4'(op - OP_CEQ);
      d.sgn  = 1'b1;
    end else if (op >= OP_CLTU && op <= OP_CGEU) begin
      d.unit = U_CMP;
      d.fn   = 4'(op - OP_CLTU) + CF_LT;
    end else if (op >= OP_CIEQ && op <= OP_CIGE) begin
      d.unit = U_CMP;
      d.fn   = 4'(op - OP_CIEQ);
      d.sgn  = 1'b1;
      d.bsel = B_SEXT;
    end else if (op >= OP_CIEQU && op <= OP_CIGEU) begin
      d.unit = U_CMP;
      d.fn   = 4'(op - OP_CIEQU);
      d.bsel = B_ZEXT;
    end
    return d;
  endfunction

endpackage

// File: rtl/cset_alu_opsel.sv
module cset_alu_opsel
  import cset_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [DATA_W-1:0] b_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  bsel_e             bsel_i,
  output logic [DATA_W-1:0] b_o
);
  localparam int PAD_W = DATA_W - IMM_W;

  always_comb begin
    unique case (bsel_i)
      B_SEXT:  b_o = {{PAD_W{imm_i[IMM_W-1]}}, imm_i};
      B_ZEXT:  b_o = {{PAD_W{1'b0}}, imm_i};
      B_HIGH:  b_o = {imm_i, {PAD_W{1'b0}}} >> (IMM_W > PAD_W ? IMM_W - PAD_W : 0);
      default: b_o = b_i;
    endcase
  end
endmodule

// File: rtl/cset_alu_arith.sv
module cset_alu_arith
  import cset_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [3:0]        fn_i,
  output logic [DATA_W-1:0] res_o
);
  logic              sub;
  logic [DATA_W-1:0] sum, neg_a;

  assign sub   = (fn_i == AF_SUB);
  assign sum   = a_i + (sub ? ~b_i : b_i) + DATA_W'(sub);
  assign neg_a = '0 - a_i;

  always_comb begin
    unique case (fn_i)
      AF_ADD, AF_SUB: res_o = sum;
      AF_ABS:         res_o = a_i[DATA_W-1] ? neg_a : a_i;
      AF_NABS:        res_o = a_i[DATA_W-1] ? a_i : neg_a;
      default:        res_o = '0;
    endcase
  end
endmodule

// File: rtl/cset_alu_logic.sv
module cset_alu_logic
  import cset_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [3:0]        fn_i,
  output logic [DATA_W-1:0] res_o
);
  always_comb begin
    unique case (fn_i)
      LF_AND:  res_o = a_i & b_i;
      LF_OR:   res_o = a_i | b_i;
      LF_XOR:  res_o = a_i ^ b_i;
      LF_ANDC: res_o = a_i & ~b_i;
      LF_EQV:  res_o = ~(a_i ^ b_i);
      LF_NAND: res_o = ~(a_i & b_i);
      LF_NOR:  res_o = ~(a_i | b_i);
      LF_ORC:  res_o = a_i | ~b_i;
      LF_NOT:  res_o = ~a_i;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/cset_alu_cmp.sv
module cset_alu_cmp
  import cset_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [3:0]        fn_i,
  input  logic              sgn_i,
  output logic [DATA_W-1:0] res_o
);
  logic eq, lt, hit;

  assign eq = (a_i == b_i);
  // flip sign bits to reuse the unsigned comparator for signed order
  assign lt = ({a_i[DATA_W-1] ^ sgn_i, a_i[DATA_W-2:0]} <
               {b_i[DATA_W-1] ^ sgn_i, b_i[DATA_W-2:0]});

  always_comb begin
    unique case (fn_i)
      CF_EQ:   hit = eq;
      CF_NE:   hit = !eq;
      CF_LT:   hit = lt;
      CF_LE:   hit = lt || eq;
      CF_GT:   hit = !lt && !eq;
      CF_GE:   hit = !lt;
      default: hit = 1'b0;
    endcase
  end

  assign res_o = {{(DATA_W-1){1'b0}}, hit};
endmodule

// File: rtl/cset_alu.sv
module cset_alu
  import cset_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o
);
  dec_t              dec;
  logic [DATA_W-1:0] b_eff, arith_res, logic_res, cmp_res, res_d;

  assign dec = decode(op_i);

  cset_alu_opsel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) i_opsel (
    .b_i(b_i), .imm_i(imm_i), .bsel_i(dec.bsel), .b_o(b_eff)
  );

  cset_alu_arith #(.DATA_W(DATA_W)) i_arith (
    .a_i(a_i), .b_i(b_eff), .fn_i(dec.fn), .res_o(arith_res)
  );

  cset_alu_logic #(.DATA_W(DATA_W)) i_logic (
    .a_i(a_i), .b_i(b_eff), .fn_i(dec.fn), .res_o(logic_res)
  );

  cset_alu_cmp #(.DATA_W(DATA_W)) i_cmp (
    .a_i(a_i), .b_i(b_eff), .fn_i(dec.fn), .sgn_i(dec.sgn), .res_o(cmp_res)
  );

  always_comb begin
    unique case (dec.unit)
      U_ARITH: res_d = arith_res;
      U_LOGIC: res_d = logic_res;
      U_CMP:   res_d = cmp_res;
      default: res_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) result_o <= res_d;
    end
  end
endmodule

// File: rtl/cset_alu_chk.sv
module cset_alu_chk
  import cset_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [OP_W-1:0]   op_i,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic [IMM_W-1:0]  imm_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] result_o
);
  localparam logic [DATA_W-1:0] W_MIN = {1'b1, {(DATA_W-1){1'b0}}};

  logic is_cmp, is_known;
  assign is_cmp   = (op_i >= 6'h14 && op_i <= 6'h1D) || (op_i >= 6'h20 && op_i <= 6'h2B);
  assign is_known = (op_i <= 6'h11) || is_cmp;

  assert_valid_lat_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(result_o)));

  assert_add_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 6'h00) |=> (result_o == $past(DATA_W'(a_i + b_i))));

  assert_abs_sign_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 6'h10) |=> (!result_o[DATA_W-1] || result_o == W_MIN));

  assert_cmp_bool_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && is_cmp) |=> (result_o[DATA_W-1:1] == '0));

  assert_unknown_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !is_known) |=> (result_o == '0));

  logic unused_ok;
  assign unused_ok = ^{b_i, imm_i};
endmodule

bind cset_alu cset_alu_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) i_cset_alu_chk (.*);

// File: tb/test_cset_alu.sv
module test_cset_alu;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [5:0]  op_i = '0;
  logic [31:0] a_i = '0, b_i = '0;
  logic [15:0] imm_i = '0;
  logic        valid_o;
  logic [31:0] result_o;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk_i = ~clk_i;

  cset_alu i_cset_alu (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input string tag, input logic [5:0] op, input logic [31:0] a,
                        input logic [31:0] b, input logic [15:0] imm, input logic [31:0] exp);
    @(negedge clk_i);
    op_i = op; a_i = a; b_i = b; imm_i = imm; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    check({tag, " valid"}, {31'b0, valid_o}, 32'd1);
    check(tag, result_o, exp);
  endtask

  task automatic t_reset;
    #5;
    check("R1 valid in reset", {31'b0, valid_o}, 32'd0);
    check("R1 result in reset", result_o, 32'd0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_hold;
    run_op("R2 load", 6'h00, 32'd40, 32'd2, 16'd0, 32'd42);
    op_i = 6'h01; a_i = 32'hFFFF; b_i = 32'h1;
    repeat (3) @(negedge clk_i);
    check("R2 valid low when idle", {31'b0, valid_o}, 32'd0);
    check("R2 result held when idle", result_o, 32'd42);
  endtask

  task automatic t_arith;
    run_op("R3 add wrap", 6'h00, 32'hFFFFFFFF, 32'd2, 16'd0, 32'd1);
    run_op("R3 add", 6'h00, 32'h12345678, 32'h11111111, 16'd0, 32'h23456789);
    run_op("R3 sub borrow", 6'h01, 32'd5, 32'd7, 16'd0, 32'hFFFFFFFE);
    run_op("R3 sub min wrap", 6'h01, 32'h80000000, 32'd1, 16'd0, 32'h7FFFFFFF);
  endtask

  task automatic t_imm_add;
    run_op("R4 addi neg imm", 6'h02, 32'd100, 32'd0, 16'hFFFF, 32'd99);
    run_op("R4 addi pos imm", 6'h02, 32'd0, 32'hDEAD, 16'h7FFF, 32'h00007FFF);
    run_op("R4 addis", 6'h03, 32'h00001234, 32'd0, 16'hABCD, 32'hABCD1234);
  endtask

  task automatic t_logic;
    logic [31:0] a = 32'hF0F000FF, b = 32'h0FF00F0F;
    run_op("R5 and",  6'h04, a, b, 16'd0, 32'h00F0000F);
    run_op("R5 or",   6'h05, a, b, 16'd0, 32'hFFF00FFF);
    run_op("R5 xor",  6'h06, a, b, 16'd0, 32'hFF000FF0);
    run_op("R5 andc", 6'h07, a, b, 16'd0, 32'hF00000F0);
    run_op("R5 eqv",  6'h08, a, b, 16'd0, 32'h00FFF00F);
    run_op("R5 nand", 6'h09, a, b, 16'd0, 32'hFF0FFFF0);
    run_op("R5 nor",  6'h0A, a, b, 16'd0, 32'h000FF000);
    run_op("R5 orc",  6'h0B, a, b, 16'd0, 32'hF0FFF0FF);
    run_op("R5 not",  6'h0C, a, b, 16'd0, 32'h0F0FFF00);
  endtask

  task automatic t_logic_imm;
    run_op("R6 andi", 6'h0D, 32'hFFFFFFFF, 32'd0, 16'h8001, 32'h00008001);
    run_op("R6 ori",  6'h0E, 32'h12340000, 32'd0, 16'hFFFF, 32'h1234FFFF);
    run_op("R6 xori", 6'h0F, 32'hFFFF0000, 32'd0, 16'h8000, 32'hFFFF8000);
  endtask

  task automatic t_abs;
    run_op("R7 abs neg",  6'h10, 32'hFFFFFFFB, 32'd0, 16'd0, 32'd5);
    run_op("R7 abs pos",  6'h10, 32'd7, 32'd0, 16'd0, 32'd7);
    run_op("R7 abs zero", 6'h10, 32'd0, 32'd0, 16'd0, 32'd0);
    run_op("R7 abs min",  6'h10, 32'h80000000, 32'd0, 16'd0, 32'h80000000);
    run_op("R7 nabs pos", 6'h11, 32'd7, 32'd0, 16'd0, 32'hFFFFFFF9);
    run_op("R7 nabs neg", 6'h11, 32'hFFFFFFFD, 32'd0, 16'd0, 32'hFFFFFFFD);
    run_op("R7 nabs min", 6'h11, 32'h80000000, 32'd0, 16'd0, 32'h80000000);
  endtask

  task automatic t_cmp_reg;
    logic [31:0] m1 = 32'hFFFFFFFF;
    run_op("R8 eq false", 6'h14, m1, 32'd1, 16'd0, 32'd0);
    run_op("R8 eq true",  6'h14, 32'd9, 32'd9, 16'd0, 32'd1);
    run_op("R8 ne",       6'h15, m1, 32'd1, 16'd0, 32'd1);
    run_op("R8 lt signed", 6'h16, m1, 32'd1, 16'd0, 32'd1);
    run_op("R8 le equal", 6'h17, 32'd9, 32'd9, 16'd0, 32'd1);
    run_op("R8 gt signed", 6'h18, m1, 32'd1, 16'd0, 32'd0);
    run_op("R8 ge equal", 6'h19, 32'd9, 32'd9, 16'd0, 32'd1);
    run_op("R8 ltu", 6'h1A, m1, 32'd1, 16'd0, 32'd0);
    run_op("R8 leu", 6'h1B, m1, 32'd1, 16'd0, 32'd0);
    run_op("R8 gtu", 6'h1C, m1, 32'd1, 16'd0, 32'd1);
    run_op("R8 geu", 6'h1D, 32'd1, m1, 16'd0, 32'd0);
  endtask

  task automatic t_cmp_imm;
    run_op("R9 ieq sext",  6'h20, 32'hFFFFFFFF, 32'd0, 16'hFFFF, 32'd1);
    run_op("R9 ilt sext",  6'h22, 32'hFFFFFFFE, 32'd0, 16'hFFFF, 32'd1);
    run_op("R9 igt sext",  6'h24, 32'hFFFFFFFE, 32'd0, 16'hFFFF, 32'd0);
    run_op("R9 ieq zext",  6'h26, 32'hFFFFFFFF, 32'd0, 16'hFFFF, 32'd0);
    run_op("R9 iltu zext", 6'h28, 32'd5, 32'd0, 16'hFFFF, 32'd1);
    run_op("R9 igtu zext", 6'h2A, 32'hFFFFFFFE, 32'd0, 16'hFFFF, 32'd1);
  endtask

  task automatic t_unused;
    run_op("R10 op 0x12", 6'h12, 32'h1234, 32'h5678, 16'hFFFF, 32'd0);
    run_op("R10 op 0x3F", 6'h3F, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'hFFFF, 32'd0);
  endtask

  initial begin
    #(20 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_hold();
    t_arith();
    t_imm_add();
    t_logic();
    t_logic_imm();
    t_abs();
    t_cmp_reg();
    t_cmp_imm();
    t_unused();
    repeat (2) @(negedge clk_i);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule